// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line-Break Generation

This block turns words written by a host into asynchronous serial frames on a single output line. A word is first held in a one-entry holding register. On an externally supplied one-cycle bit-rate tick it is moved into a shift register, and from there it goes out one bit per tick. Each frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. Between frames the line rests high.

Two further line conditions are available. First, when the transmitter is switched on, a full frame of ones is sent as a preamble before anything else. Second, while the break control is held, the block sends frames of all zeros, and when the control is released it sends at least one high bit.

The block keeps two status flags: holding-register-empty and transmission-complete. Each flag has its own enable, and the enabled flags are ORed into a single interrupt request. If the transmitter is turned off in the middle of a frame, that frame still finishes. The block keeps driving the pin until the frame is done.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `tx_oe` is 0 (with `tx_en` low), `flag_empty` is 1, `flag_done` is 1 and `irq` is 0.
- R2: A data frame has the following layout. One start bit of 0 comes first. Then come `wr_data` bits 0 upward: 8 bits when `nine_bit` is 0, or 9 bits when it is 1, with the value of `nine_bit` taken at load. The frame ends with one stop bit of 1. Each bit is held on `txd` from the cycle after one tick to the cycle after the next tick.
- R3: A write stores `wr_data` in the holding register and clears `flag_empty`. The word moves to the shifter only under three conditions, all at once: on a tick, while `tx_en` has been high for this cycle and the previous one, and while the shifter is idle or sending its last bit. The move sets `flag_empty`. A word written while disabled is not sent.
- R4: The following clear `flag_done`: a write, or any frame load (data, preamble, break or mark). `flag_done` sets on a tick where the shifter is idle or on its last bit and nothing is loaded. Whenever `flag_done` is 1, the shifter is idle.
- R5: When `tx_en` rises, the first frame sent is a preamble of ones lasting one full frame (10 bit times for 8-bit words, 11 for 9-bit). It is sent before any pending data or break.
- R6: While `brk_req` is 1 and the transmitter is enabled, every frame loaded is all zeros, stop bit included, with the frame length. Break frames take priority over data.
- R7: After a break frame, if `brk_req` is 0 at the next load point, a single high bit (one bit time) is sent before any data.
- R8: If `tx_en` falls mid-frame, the frame completes and `tx_oe` stays 1 until the frame has ended. After that, `tx_oe` follows `tx_en` and `flag_done` sets even if a word is still held.
- R9: `irq` = (`flag_empty` AND `ie_empty`) OR (`flag_done` AND `ie_done`).
- R10: `txd` changes only in the cycle following a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Send line break while high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send (bit 8 used in 9-bit mode) |
| ie_empty | input | 1 | Interrupt enable for holding-register-empty |
| ie_done | input | 1 | Interrupt enable for transmission-complete |
| txd | output | 1 | Serial output line |
| tx_oe | output | 1 | Pin drive enable |
| flag_empty | output | 1 | Holding register empty |
| flag_done | output | 1 | Transmission complete |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a transmitter turned off partway through a frame while another word waits in the holding register. This must complete the frame and hold the pin, then report completion without sending the waiting word. On re-enable, it must send a preamble before that word. The stimulus watches the decoded line for a start bit, lets a few ticks pass, and drops `tx_en`. It then writes while disabled and re-enables later. Every cycle is compared against a queue-based model of the line, which also covers the break-to-mark handover and the preamble that follows enable.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int SHORT_W = 8;
  localparam int LONG_W  = 9;
  localparam int FRAME_W = LONG_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_PRE,
    SRC_BRK,
    SRC_MARK,
    SRC_DATA
  } src_e;

  // Bit times in one frame for the chosen word length.
  function automatic logic [CNT_W-1:0] frame_len(input logic nine);
    return nine ? CNT_W'(LONG_W + 2) : CNT_W'(SHORT_W + 2);
  endfunction

  // Frame laid out for shifting out of bit 0: start, data LSB first, stop.
  function automatic logic [FRAME_W-1:0] data_frame(input logic [LONG_W-1:0] d,
                                                    input logic nine);
    logic [FRAME_W-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < LONG_W; i++) begin
      if (i < SHORT_W || nine) f[i+1] = d[i];
    end
    return f;
  endfunction
endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               load_en,
  input  logic [FRAME_W-1:0] load_bits,
  input  logic [CNT_W-1:0]   load_len,
  output logic               ser_bit,
  output logic               busy,
  output logic               slot_free
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
    end else if (load_en) begin
      shreg <= load_bits;
      left  <= load_len;
    end else if (bit_tick) begin
      if (left > CNT_W'(1)) begin
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - CNT_W'(1);
      end else begin
        shreg <= '1;
        left  <= '0;
      end
    end
  end

  assign busy      = (left != '0);
  assign slot_free = (left <= CNT_W'(1));
  assign ser_bit   = busy ? shreg[0] : 1'b1;

  assert_steady_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(ser_bit));

  assert_load_at_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (bit_tick && slot_free));
endmodule

// File: rtl/uart_tx_source.sv
module uart_tx_source
  import uart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               brk_req,
  input  logic               nine_bit,
  input  logic               hold_full,
  input  logic [LONG_W-1:0]  hold_data,
  input  logic               slot,
  output src_e               pick,
  output logic               load_en,
  output logic [FRAME_W-1:0] load_bits,
  output logic [CNT_W-1:0]   load_len,
  output logic               data_taken
);
  logic en_q, pre_pend, last_brk, en_ok;

  assign en_ok = tx_en & en_q;

  always_comb begin
    pick = SRC_NONE;
    if (slot && en_ok) begin
      if (pre_pend)       pick = SRC_PRE;
      else if (brk_req)   pick = SRC_BRK;
      else if (last_brk)  pick = SRC_MARK;
      else if (hold_full) pick = SRC_DATA;
    end
  end

  always_comb begin
    load_len = frame_len(nine_bit);
    case (pick)
      SRC_BRK:  load_bits = '0;
      SRC_DATA: load_bits = data_frame(hold_data, nine_bit);
      SRC_MARK: begin load_bits = '1; load_len = CNT_W'(1); end
      default:  load_bits = '1;
    endcase
  end

  assign load_en    = (pick != SRC_NONE);
  assign data_taken = (pick == SRC_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pre_pend <= 1'b0;
      last_brk <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (!tx_en)              pre_pend <= 1'b0;
      else if (!en_q)          pre_pend <= 1'b1;
      else if (pick == SRC_PRE) pre_pend <= 1'b0;
      if (pick == SRC_BRK)     last_brk <= 1'b1;
      else if (load_en)        last_brk <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic data_taken,
  input  logic slot,
  input  logic load_en,
  input  logic ie_empty,
  input  logic ie_done,
  output logic flag_empty,
  output logic flag_done,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_empty <= 1'b1;
      flag_done  <= 1'b1;
    end else begin
      if (wr_en)           flag_empty <= 1'b0;
      else if (data_taken) flag_empty <= 1'b1;
      if (wr_en)           flag_done  <= 1'b0;
      else if (slot)       flag_done  <= !load_en;
    end
  end

  assign irq = (flag_empty & ie_empty) | (flag_done & ie_done);

  assert_write_clears_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!flag_empty && !flag_done));

  assert_move_sets_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_taken && !wr_en) |=> flag_empty);
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              nine_bit,
  input  logic              wr_en,
  input  logic [LONG_W-1:0] wr_data,
  input  logic              ie_empty,
  input  logic              ie_done,
  output logic              txd,
  output logic              tx_oe,
  output logic              flag_empty,
  output logic              flag_done,
  output logic              irq
);
  logic [LONG_W-1:0]  hold;
  logic               hold_full, slot, load_en, data_taken;
  logic               ser_bit, busy, slot_free;
  logic [FRAME_W-1:0] load_bits;
  logic [CNT_W-1:0]   load_len;
  src_e               pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold <= '0;
    else if (wr_en) hold <= wr_data;
  end

  assign hold_full = ~flag_empty;
  assign slot      = bit_tick & slot_free;

  uart_tx_source u_source (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
    .nine_bit(nine_bit), .hold_full(hold_full), .hold_data(hold), .slot(slot),
    .pick(pick), .load_en(load_en), .load_bits(load_bits), .load_len(load_len),
    .data_taken(data_taken)
  );

  uart_tx_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load_en(load_en),
    .load_bits(load_bits), .load_len(load_len),
    .ser_bit(ser_bit), .busy(busy), .slot_free(slot_free)
  );

  uart_tx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .data_taken(data_taken),
    .slot(slot), .load_en(load_en), .ie_empty(ie_empty), .ie_done(ie_done),
    .flag_empty(flag_empty), .flag_done(flag_done), .irq(irq)
  );

  assign txd   = ser_bit;
  assign tx_oe = tx_en | busy;

  assert_done_means_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_done |-> !busy);

  assert_frame_runs_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot) |=> busy);

  assert_break_drives_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pick == SRC_BRK) |=> !txd);
endmodule

// File: tb/uart_tx_brk_bench.sv
module uart_tx_brk_bench;
  logic clk = 0, rst_n = 0, bit_tick = 0, tx_en = 0, brk_req = 0, nine_bit = 0;
  logic wr_en = 0, ie_empty = 0, ie_done = 0;
  logic [8:0] wr_data = 0;
  logic txd, tx_oe, flag_empty, flag_done, irq;

  uart_tx_brk u_uart_tx_brk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .brk_req(brk_req),
    .nine_bit(nine_bit), .wr_en(wr_en), .wr_data(wr_data), .ie_empty(ie_empty),
    .ie_done(ie_done), .txd(txd), .tx_oe(tx_oe), .flag_empty(flag_empty),
    .flag_done(flag_done), .irq(irq)
  );

  always #10 clk = ~clk;   // 50 MHz

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Tick source: one pulse every 5 clocks, driven just after the edge.
  int tdiv = 0;
  always @(posedge clk) begin
    #2;
    if (tdiv == 4) begin bit_tick = 1; tdiv = 0; end
    else begin bit_tick = 0; tdiv++; end
  end

  // Behavioural line model: a queue of bits still to appear on the line.
  bit m_q[$];
  bit m_en_q, m_pre, m_lastbrk, m_empty = 1, m_done = 1, tick_prev;
  logic [8:0] m_hold;
  always @(posedge clk) begin
    tick_prev = bit_tick;
    if (!rst_n) begin
      m_q.delete(); m_en_q = 0; m_pre = 0; m_lastbrk = 0;
      m_empty = 1; m_done = 1; m_hold = 0;
    end else begin
      bit slot, loaded, taken, ena;
      int len;
      slot = bit_tick && (m_q.size() <= 1);
      loaded = 0; taken = 0;
      ena = tx_en && m_en_q;
      len = nine_bit ? 11 : 10;
      if (bit_tick && m_q.size() > 1) void'(m_q.pop_front());
      if (slot) begin
        m_q.delete();
        if (ena && m_pre) begin
          for (int i = 0; i < len; i++) m_q.push_back(1'b1);
          m_pre = 0; m_lastbrk = 0; loaded = 1;
        end else if (ena && brk_req) begin
          for (int i = 0; i < len; i++) m_q.push_back(1'b0);
          m_lastbrk = 1; loaded = 1;
        end else if (ena && m_lastbrk) begin
          m_q.push_back(1'b1); m_lastbrk = 0; loaded = 1;
        end else if (ena && !m_empty) begin
          m_q.push_back(1'b0);
          for (int i = 0; i < len - 2; i++) m_q.push_back(m_hold[i]);
          m_q.push_back(1'b1);
          m_lastbrk = 0; loaded = 1; taken = 1;
        end
      end
      if (!tx_en) m_pre = 0;
      else if (!m_en_q) m_pre = 1;
      if (wr_en) begin
        m_hold = wr_data; m_empty = 0; m_done = 0;
      end else begin
        if (taken) m_empty = 1;
        if (slot) m_done = !loaded;
      end
      m_en_q = tx_en;
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_txd, e_oe, e_irq;
      e_txd = (m_q.size() > 0) ? m_q[0] : 1'b1;
      e_oe  = tx_en || (m_q.size() > 0);
      e_irq = (m_empty && ie_empty) || (m_done && ie_done);
      chk(txd == e_txd, "R2 txd", txd, e_txd);
      chk(tx_oe == e_oe, "R8 tx_oe", tx_oe, e_oe);
      chk(flag_empty == m_empty, "R3 flag_empty", flag_empty, m_empty);
      chk(flag_done == m_done, "R4 flag_done", flag_done, m_done);
      chk(irq == e_irq, "R9 irq", irq, e_irq);
    end
  end

  // Line decoder and R10 change monitor.
  int dmode = 0, dcnt = 0, brk_cnt = 0, mark_cnt = 0;
  bit dec_nine = 0, last_txd = 1;
  logic [8:0] dacc;
  logic [8:0] rx_q[$];
  always @(negedge clk) begin
    if (rst_n) begin
      if (txd != last_txd) chk(tick_prev, "R10 txd moved without tick", 0, 1);
      last_txd = txd;
      if (tick_prev) begin
        case (dmode)
          0: if (!txd) begin dmode = 1; dcnt = 0; dacc = 0; end
          1: if (dcnt < (dec_nine ? 9 : 8)) begin dacc[dcnt] = txd; dcnt++; end
             else if (txd) begin rx_q.push_back(dacc); dmode = 0; end
             else begin if (dacc == 0) brk_cnt++; dmode = 2; end
          default: if (txd) begin mark_cnt++; dmode = 0; end
        endcase
      end
    end
  end

  task automatic step(); @(posedge clk); #3; endtask
  task automatic write(input logic [8:0] d);
    step(); wr_en = 1; wr_data = d; step(); wr_en = 0;
  endtask
  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); while (!bit_tick) @(posedge clk); end
    #3;
  endtask
  task automatic expect_rx(input logic [8:0] v, input string req);
    if (rx_q.size() == 0) chk(0, req, -1, v);
    else begin
      logic [8:0] g;
      g = rx_q.pop_front();
      chk(g == v, req, g, v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int hi;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(tx_oe == 0, "R1 tx_oe", tx_oe, 0);
    chk(flag_empty == 1, "R1 empty", flag_empty, 1);
    chk(flag_done == 1, "R1 done", flag_done, 1);
    chk(irq == 0, "R1 irq", irq, 0);
    step(); ie_done = 1;
    @(negedge clk); chk(irq == 1, "R9 done irq", irq, 1);
    ie_done = 0;

    // Preamble then two 8-bit words
    step(); tx_en = 1;
    write(9'h0A5);
    hi = 0;
    forever begin
      @(negedge clk);
      if (tick_prev) begin if (!txd) break; hi++; end
    end
    chk(hi >= 10, "R5 preamble length", hi, 10);
    while (!flag_empty) step();
    write(9'h03C);
    while (!flag_done) step();
    expect_rx(9'h0A5, "R2 8-bit first");
    expect_rx(9'h03C, "R2 8-bit second");

    // 9-bit words
    step(); nine_bit = 1; dec_nine = 1;
    write(9'h1F0);
    while (!flag_empty) step();
    write(9'h055);
    while (!flag_done) step();
    expect_rx(9'h1F0, "R2 9-bit first");
    expect_rx(9'h055, "R2 9-bit second");

    // Break, release, then data
    step(); brk_req = 1;
    wait_ticks(25);
    brk_req = 0;
    write(9'h10F);
    while (!flag_done) step();
    chk(brk_cnt >= 1, "R6 break seen", brk_cnt, 1);
    chk(mark_cnt >= 1, "R7 mark after break", mark_cnt, 1);
    expect_rx(9'h10F, "R7 data after break");

    // Disable mid-frame
    step(); nine_bit = 0; dec_nine = 0;
    write(9'h05A);
    while (dmode != 1) step();
    wait_ticks(3);
    tx_en = 0;
    @(negedge clk); chk(tx_oe == 1, "R8 pin held mid-frame", tx_oe, 1);
    while (!flag_done) step();
    @(negedge clk);
    chk(tx_oe == 0, "R8 pin released", tx_oe, 0);
    expect_rx(9'h05A, "R8 frame finished");
    write(9'h077);
    wait_ticks(30);
    @(negedge clk);
    chk(flag_done == 1, "R8 done while disabled", flag_done, 1);
    chk(flag_empty == 0, "R3 word still held", flag_empty, 0);
    chk(rx_q.size() == 0, "R3 nothing sent disabled", rx_q.size(), 0);
    step(); ie_empty = 1;
    @(negedge clk); chk(irq == 0, "R9 empty irq masked by full", irq, 0);
    step(); tx_en = 1;
    while (!flag_empty) step();
    @(negedge clk); chk(irq == 1, "R9 empty irq", irq, 1);
    while (!flag_done) step();
    expect_rx(9'h077, "R5 held word after preamble");
    wait_ticks(2);
    summary();
  end
endmodule